// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer, nine bits wide. A producer writes into it on one clock and a consumer reads from it on another clock, and the two clocks have no fixed relationship. The depth is a power of two, chosen by a parameter from 256 to 8192 words. Each side keeps a binary pointer. The pointer also crosses to the other clock domain as Gray code through a two-flop synchronizer.

Four active-low level indicators report occupancy:

- The write side drives full and almost-full from its own pointer and the synchronized read pointer.
- The read side drives empty and almost-empty from its own pointer and the synchronized write pointer.

Because of the synchronizer delay, each indicator can be pessimistic for a few cycles after the far side moves. It is never optimistic.

Two thresholds set where the almost indicators switch: an empty offset n and a full offset m. Both reset to 7. A small write-clock port loads a new value into either offset, and the value is clamped into a legal range. Loading is only meaningful while the buffer is empty after reset. The empty offset is then treated as quasi-static by the read side.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, that domain is cleared. After reset, `empty_n`=0, `aempty_n`=0, `afull_n`=1, `full_n`=1 and `rd_data`=0, and both offsets hold 7.
- R2: Words leave on `rd_data` in the order they were accepted, and all nine bits are preserved. `rd_data` takes the next word on the read-clock edge that accepts a read (`rd_en`=1 while `empty_n`=1).
- R3: Once the pointers have settled, `empty_n` is 0 exactly when the word count is 0. It changes only on the rising edge of `rclk`.
- R4: Once settled, `aempty_n` is 0 for word counts 0 to n and 1 for counts above n. It changes only on the rising edge of `rclk`.
- R5: Once settled, `afull_n` is 0 for word counts from DEPTH-m up to DEPTH and 1 below DEPTH-m. It changes only on the rising edge of `wclk`.
- R6: `full_n` is 0 exactly when the word count equals DEPTH, and the count never exceeds DEPTH. It changes only on the rising edge of `wclk`.
- R7: A write presented while `full_n`=0 is dropped. It changes neither the write pointer nor the stored words.
- R8: A read presented while `empty_n`=0 is dropped. `rd_data` holds its value and the read pointer does not move.
- R9: A write-clock edge with `cfg_we`=1 loads `cfg_val` into the empty offset when `cfg_sel`=0, or into the full offset when `cfg_sel`=1. The other offset is left unchanged.
- R10: A loaded value of 0 becomes 1, and a loaded value above DEPTH-2 becomes DEPTH-2. The offsets therefore always lie between 1 and DEPTH-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| afull_n | output | 1 | Low when the count is at least DEPTH-m |
| cfg_we | input | 1 | Offset load strobe (write clock) |
| cfg_sel | input | 1 | 0 selects the empty offset, 1 selects the full offset |
| cfg_val | input | log2(DEPTH) | Offset value to load |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read |
| empty_n | output | 1 | Low when the buffer holds no words |
| aempty_n | output | 1 | Low when the count is at most n |

## Verification
A corrupted pointer shows up on the port where it is used. A bad read pointer produces an out-of-order or repeated word on `rd_data` at the very next accepted read. A bad write pointer makes a stored word vanish, which is seen when that word is drained, and it also shifts the level indicators about three cycles of the far clock later. A wrong offset register never disturbs the data; it shows only as an almost indicator switching at the wrong count. The bench therefore steps the count across every threshold, once with the default offsets and again with loaded and clamped ones. A dropped access that wrongly took effect shows up as an unexpected word when the buffer is drained afterwards.

// File: rtl/dcf_pkg.sv
// Shared helpers for the dual-clock FIFO: Gray/binary conversion.
// Assumes pointers are no wider than PTR_MAX_W bits.
package dcf_pkg;
    localparam int PTR_MAX_W = 16;

    // Binary to reflected Gray code.
    function automatic logic [PTR_MAX_W-1:0] bin2gray(input logic [PTR_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [PTR_MAX_W-1:0] gray2bin(input logic [PTR_MAX_W-1:0] g);
        logic [PTR_MAX_W-1:0] r;
        r[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            r[i] = r[i+1] ^ g[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/dcf_mem.sv
// Storage array: one synchronous write port on the write clock and one
// asynchronous read port. Assumes the control logic never writes a slot
// that has not been read yet.
module dcf_mem #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram [DEPTH];

    // Store the accepted word at the write address.
    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/dcf_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer. Assumes the input
// changes by at most one bit between samples, and that STAGES >= 2.
module dcf_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pointer through the synchronizing chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr.sv
// Write-clock domain: write pointer, full and almost-full flags, and the
// two offset registers with clamping. Assumes rgray_s is the read pointer
// already synchronized into this domain.
module dcf_wr
    import dcf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DEF_OFF = 7
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_val,
    input  logic [ADDR_W:0]   rgray_s,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              mem_we,
    output logic              full_n,
    output logic              afull_n,
    output logic [ADDR_W-1:0] e_off
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] f_off;
    logic [PW-1:0]     wptr, wptr_nxt, rbin_s, cnt_nxt, cnt_now, af_lvl;
    logic              wr_ok;

    // Force a requested offset into the range 1 .. DEPTH-2.
    function automatic logic [ADDR_W-1:0] clamp_off(input logic [ADDR_W-1:0] v);
        if (v == '0) return ADDR_W'(1);
        if (v > ADDR_W'(DEPTH - 2)) return ADDR_W'(DEPTH - 2);
        return v;
    endfunction

    // Next pointer, occupancy and almost-full threshold.
    always_comb begin
        wr_ok    = wr_en && full_n;
        wptr_nxt = wptr + PW'(wr_ok);
        rbin_s   = PW'(gray2bin(PTR_MAX_W'(rgray_s)));
        cnt_nxt  = wptr_nxt - rbin_s;
        cnt_now  = wptr - rbin_s;
        af_lvl   = PW'(DEPTH) - {1'b0, f_off};
    end

    // Pointer and write-side flag registers.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wptr    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
        end else begin
            wptr    <= wptr_nxt;
            wgray   <= PW'(bin2gray(PTR_MAX_W'(wptr_nxt)));
            full_n  <= (cnt_nxt != PW'(DEPTH));
            afull_n <= (cnt_nxt < af_lvl);
        end
    end

    // Offset registers loaded through the configuration port.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            e_off <= ADDR_W'(DEF_OFF);
            f_off <= ADDR_W'(DEF_OFF);
        end else if (cfg_we) begin
            if (cfg_sel) f_off <= clamp_off(cfg_val);
            else         e_off <= clamp_off(cfg_val);
        end
    end

    assign mem_we = wr_ok;
    assign waddr  = wptr[ADDR_W-1:0];

    p_reset_state_r1: assert property (@(posedge wclk)
        !rst_n |=> (full_n && afull_n && e_off == ADDR_W'(DEF_OFF) && f_off == ADDR_W'(DEF_OFF)));
    p_full_has_afull_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);
    p_no_overflow_r6: assert property (@(posedge wclk) disable iff (!rst_n)
        cnt_now <= PW'(DEPTH));
    p_drop_write_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !full_n) |=> $stable(wptr));
    p_sel_keeps_other_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> $stable(e_off));
    p_offset_range_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        e_off >= ADDR_W'(1) && e_off <= ADDR_W'(DEPTH - 2) &&
        f_off >= ADDR_W'(1) && f_off <= ADDR_W'(DEPTH - 2));
endmodule

// File: rtl/dcf_rd.sv
// Read-clock domain: read pointer, registered read data, and the empty
// and almost-empty flags. Assumes wgray_s is the synchronized write pointer
// and that e_off is held steady whenever reads are in progress.
module dcf_rd
    import dcf_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [ADDR_W-1:0] e_off,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] rptr, rptr_nxt, wbin_s, cnt_nxt, cnt_now;
    logic          rd_ok;

    // Next pointer and occupancy as seen from the read side.
    always_comb begin
        rd_ok    = rd_en && empty_n;
        rptr_nxt = rptr + PW'(rd_ok);
        wbin_s   = PW'(gray2bin(PTR_MAX_W'(wgray_s)));
        cnt_nxt  = wbin_s - rptr_nxt;
        cnt_now  = wbin_s - rptr;
    end

    // Pointer, output word and read-side flag registers.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rptr     <= '0;
            rgray    <= '0;
            rd_data  <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rptr     <= rptr_nxt;
            rgray    <= PW'(bin2gray(PTR_MAX_W'(rptr_nxt)));
            if (rd_ok) rd_data <= mem_rdata;
            empty_n  <= (cnt_nxt != '0);
            aempty_n <= (cnt_nxt > {1'b0, e_off});
        end
    end

    assign raddr = rptr[ADDR_W-1:0];

    p_reset_state_r1: assert property (@(posedge rclk)
        !rst_n |=> (!empty_n && !aempty_n && rd_data == '0));
    p_occupancy_bound_r3: assert property (@(posedge rclk) disable iff (!rst_n)
        cnt_now <= PW'(DEPTH));
    p_empty_has_aempty_r4: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
    p_drop_read_r8: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && !empty_n) |=> ($stable(rptr) && $stable(rd_data)));
endmodule

// File: rtl/dual_clk_flag_fifo.sv
// Top level of the dual-clock FIFO. It joins the storage array, the two
// clock-domain halves and the Gray pointer synchronizers. Assumes DEPTH is
// a power of two between 256 and 8192, and that rst_n is held low for at
// least two edges of each clock.
module dual_clk_flag_fifo #(
    parameter  int DEPTH       = 256,
    parameter  int DATA_W      = 9,
    parameter  int DEF_OFF     = 7,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_val,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr, e_off;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
        .wclk (wclk), .we (mem_we), .waddr (waddr), .wdata (wr_data),
        .raddr (raddr), .rdata (mem_rdata)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_r2w (
        .clk (wclk), .rst_n (rst_n), .d (rgray), .q (rgray_s)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_w2r (
        .clk (rclk), .rst_n (rst_n), .d (wgray), .q (wgray_s)
    );

    dcf_wr #(.ADDR_W(ADDR_W), .DEF_OFF(DEF_OFF)) i_wr (
        .wclk (wclk), .rst_n (rst_n), .wr_en (wr_en),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_val (cfg_val),
        .rgray_s (rgray_s), .wgray (wgray), .waddr (waddr), .mem_we (mem_we),
        .full_n (full_n), .afull_n (afull_n), .e_off (e_off)
    );

    dcf_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd (
        .rclk (rclk), .rst_n (rst_n), .rd_en (rd_en), .wgray_s (wgray_s),
        .e_off (e_off), .mem_rdata (mem_rdata), .raddr (raddr), .rgray (rgray),
        .rd_data (rd_data), .empty_n (empty_n), .aempty_n (aempty_n)
    );
endmodule

// File: tb/test_dual_clk_flag_fifo.sv
// Bench for dual_clk_flag_fifo. It walks a table of occupancy targets with
// expected flags, then runs directed tests for reset, dropped accesses and
// offset loading.
module test_dual_clk_flag_fifo;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
    localparam int DEPTH       = 256;
    localparam int DW          = 9;
    localparam int AW          = 8;

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] cfg_val = '0;
    logic [DW-1:0] rd_data;
    logic          full_n, afull_n, empty_n, aempty_n;

    int checks = 0, errors = 0;
    int cnt = 0, wseq = 0, rseq = 0, bn = 7, bm = 7;
    logic [DW-1:0] last_rd = '0;
    bit done = 0;

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    dual_clk_flag_fifo #(.DEPTH(DEPTH)) i_dual_clk_flag_fifo (
        .wclk (wclk), .rclk (rclk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .full_n (full_n), .afull_n (afull_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
        .cfg_val (cfg_val), .rd_en (rd_en), .rd_data (rd_data),
        .empty_n (empty_n), .aempty_n (aempty_n)
    );

    // Order of the flag vector: {empty_n, aempty_n, afull_n, full_n}.
    localparam int NV = 15;
    localparam int VCNT [NV] = '{0, 1, 7, 8, 100, 248, 249, 255, 256, 255, 248, 8, 7, 1, 0};
    localparam logic [3:0] VFLG [NV] = '{4'b0011, 4'b1011, 4'b1011, 4'b1111, 4'b1111,
                                         4'b1111, 4'b1101, 4'b1101, 4'b1100, 4'b1101,
                                         4'b1111, 4'b1111, 4'b1011, 4'b1011, 4'b0011};

    function automatic logic [DW-1:0] pat(input int s);
        return DW'((s * 37 + 5) % 512);
    endfunction

    function automatic int clampv(input int v);
        if (v < 1) return 1;
        if (v > DEPTH - 2) return DEPTH - 2;
        return v;
    endfunction

    function automatic logic [3:0] exp_flags();
        return {cnt != 0, cnt > bn, cnt < DEPTH - bm, cnt != DEPTH};
    endfunction

    task automatic chk_flags(input string tag, input logic [3:0] exp);
        checks++;
        if ({empty_n, aempty_n, afull_n, full_n} !== exp) begin
            errors++;
            $display("FAIL %s flags act=%b exp=%b count=%0d", tag,
                     {empty_n, aempty_n, afull_n, full_n}, exp, cnt);
        end
    endtask

    task automatic chk_data(input string tag, input logic [DW-1:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, exp);
        end
    endtask

    task automatic do_reset();
        wr_en = 0; rd_en = 0; cfg_we = 0; rst_n = 0;
        repeat (4) @(negedge rclk);
        rst_n = 1;
        cnt = 0; wseq = 0; rseq = 0; bn = 7; bm = 7; last_rd = '0;
        @(negedge rclk);
        chk_flags("R1 reset", 4'b0011);
        chk_data("R1 reset", '0);
    endtask

    // Present k writes; those made while full carry junk and are not modelled.
    task automatic push_n(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge wclk);
            wr_en = 1;
            if (cnt < DEPTH) begin
                wr_data = pat(wseq); wseq++; cnt++;
            end else begin
                wr_data = ~pat(wseq);
            end
        end
        @(negedge wclk);
        wr_en = 0;
    endtask

    // Present k reads and check each returned word.
    task automatic pop_n(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge rclk);
            rd_en = 1;
            @(posedge rclk);
            #1;
            if (cnt > 0) begin
                chk_data("R2 order", pat(rseq));
                last_rd = pat(rseq); rseq++; cnt--;
            end else begin
                chk_data("R8 read while empty", last_rd);
            end
        end
        @(negedge rclk);
        rd_en = 0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
    endtask

    task automatic go_to(input int target);
        if (target > cnt) push_n(target - cnt);
        else if (target < cnt) pop_n(cnt - target);
        settle();
    endtask

    task automatic cfg(input logic sel, input int v);
        @(negedge wclk);
        cfg_we = 1; cfg_sel = sel; cfg_val = AW'(v);
        @(negedge wclk);
        cfg_we = 0;
        if (sel) bm = clampv(v); else bn = clampv(v);
    endtask

    task automatic probe(input string tag, input int target);
        go_to(target);
        chk_flags(tag, exp_flags());
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Table walk with default offsets: R1 R3 R4 R5 R6.
        for (int i = 0; i < NV; i++) begin
            go_to(VCNT[i]);
            chk_flags("R1 R3 R4 R5 R6 table", VFLG[i]);
        end

        // R8: reads on an empty buffer are dropped.
        pop_n(3);
        settle();
        chk_flags("R8 still empty", 4'b0011);
        go_to(1);
        pop_n(1);

        // R7: writes while full are dropped; draining shows no junk words.
        go_to(DEPTH);
        push_n(3);
        settle();
        chk_flags("R7 full held", 4'b1100);
        go_to(0);
        chk_flags("R7 drained", 4'b0011);

        // R9: load distinct offsets through the select bit.
        do_reset();
        cfg(1'b0, 20);
        cfg(1'b1, 30);
        probe("R9 empty offset 20 low", 20);
        probe("R9 empty offset 20 high", 21);
        probe("R9 full offset 30 high", 225);
        probe("R9 full offset 30 low", 226);
        go_to(0);

        // R10: a loaded zero becomes 1.
        do_reset();
        cfg(1'b0, 0);
        cfg(1'b1, 0);
        probe("R10 min n count1", 1);
        probe("R10 min n count2", 2);
        probe("R10 min m count254", 254);
        probe("R10 min m count255", 255);
        probe("R10 min m full", 256);
        go_to(0);

        // R10: a loaded value above DEPTH-2 becomes DEPTH-2.
        do_reset();
        cfg(1'b0, 255);
        cfg(1'b1, 255);
        probe("R10 max m count1", 1);
        probe("R10 max m count2", 2);
        probe("R10 max n count254", 254);
        probe("R10 max n count255", 255);
        go_to(0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule